// File: doc/BRIEF.md
# Chunked burst SPI command master

This block is the master side of a register-access link over SPI. A client asks for one transfer by giving a direction, a starting word address on the remote device and a length in bytes. The engine splits the transfer into frames whose payload never exceeds a fixed limit. Each frame begins with a 32-bit command word. The payload then streams out of a local byte buffer for writes, or into that buffer for reads. Between frames the remote word address and the local byte pointer both move forward.

The client sees a busy flag for the length of the job, a one-cycle done pulse at the end, and a one-cycle error pulse when a request is refused. The local buffer pointer starts at byte 0 for every request. The SPI clock is a fixed division of the system clock. A single-frame mode refuses any request that would need more than one frame.

Top module: `spi_burst_master`

## Requirements
- R1: A request of L bytes is sent as ceil(L/256) frames. Frame n carries min(L - 256n, 256) payload bytes after a 4-byte command word. A request of length 0 sends no frame and still completes with done.
- R2: The command word is sent first, most significant bit first. Bit 31 is 1 for a write and 0 for a read. Bits 30:25 hold the frame's payload word count modulo 64 for reads, and are 0 for writes. Bits 24:4 hold the frame's word address. Bits 3:0 are 0.
- R3: The word address of each frame is the previous frame's word address plus that frame's payload bytes divided by 4. The local buffer pointer moves forward by the frame's payload bytes, starting from 0.
- R4: In a write, payload byte j of a frame is read from the buffer at pointer + j. It is sent right after the command word, most significant bit first.
- R5: In a read, each byte received after the command word is written to the buffer at pointer + j. Bytes received during the command word are never written. MOSI carries zeros during the read payload.
- R6: A request whose length is not a multiple of 4 is refused. err pulses for one cycle in the cycle after the request, busy stays low, and no frame is sent.
- R7: In single-frame mode, a length above 256 bytes is refused in the same way as R6. A length of 256 or less is carried out as one frame.
- R8: Chip select (active low) stays low for the whole of each frame. It is high between frames for at least one full SPI clock period. SCK is low whenever chip select is high. MOSI changes on the falling SCK edge, and MISO is sampled on the rising edge.
- R9: busy is high from the cycle after a request is accepted until done. done is a single-cycle pulse after the final frame, and busy is low in the done cycle.
- R10: A request presented while busy is ignored. It causes no error pulse and no extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqWrite | input | 1 | 1 = write to remote device, 0 = read |
| reqSingle | input | 1 | 1 = refuse requests needing more than one frame |
| reqAddr | input | ADDR_W | Starting remote word address |
| reqLen | input | LEN_W | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle request refusal pulse |
| sclk | output | 1 | SPI clock, idle low |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| bufRdAddr | output | LEN_W | Buffer byte address of the next write payload byte |
| bufRdData | input | 8 | Buffer data at bufRdAddr, same cycle |
| bufWrEn | output | 1 | Buffer write strobe for received payload |
| bufWrAddr | output | LEN_W | Buffer byte address for received payload |
| bufWrData | output | 8 | Received payload byte |

## Verification
Some properties are checked on every cycle inside the design. These are that SCK stays low while chip select is high, that a frame's payload never exceeds the limit and is never empty, that the remaining length shrinks at each advance, that buffer writes occur only in reads, and that the error, busy and done flags keep their pulse relations. Other properties can only be seen from the bench's SPI device model across whole transfers. These are the frame count and frame lengths, the exact command words including the word count that wraps to 0 for a 64-word read, the address stepping across frames, the payload bytes in both directions, and the idle gap between frames. The bench sweeps lengths around the 256-byte boundary in both directions, zero length, refused lengths, single-frame mode and a request injected while busy.

// File: rtl/spib_pkg.sv
`timescale 1ns/1ps
package spib_pkg;
  localparam int HDR_BYTES = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic startFrame;
    logic rise;
    logic fall;
    logic endFrame;
    logic advance;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic remZero;
    logic tick;
    logic sclkHigh;
    logic bitLast;
    logic byteLast;
  } dpStat_t;
endpackage

// File: rtl/spib_ctrl.sv
`timescale 1ns/1ps
module spib_ctrl
  import spib_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MAX_BYTES = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqSingle,
  input  logic [LEN_W-1:0] reqLen,
  input  dpStat_t          stat,
  output dpCmd_t           cmd,
  output logic             busy,
  output logic             done,
  output logic             err
);
  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_SHIFT, S_GAP, S_DONE} state_t;

  state_t state, stateNxt;
  logic   gapHalf, gapHalfNxt;
  logic   errQ;
  logic   lenBad;

  assign lenBad = (reqLen[1:0] != 2'b00) ||
                  (reqSingle && (reqLen > LEN_W'(MAX_BYTES)));

  always_comb begin
    stateNxt   = state;
    gapHalfNxt = gapHalf;
    cmd        = '0;
    case (state)
      S_IDLE: begin
        if (reqValid && !lenBad) begin
          cmd.latchReq = 1'b1;
          stateNxt     = S_NEXT;
        end
      end
      S_NEXT: begin
        if (stat.remZero) begin
          stateNxt = S_DONE;
        end else begin
          cmd.startFrame = 1'b1;
          stateNxt       = S_SHIFT;
        end
      end
      S_SHIFT: begin
        if (stat.tick) begin
          if (!stat.sclkHigh) begin
            cmd.rise = 1'b1;
          end else begin
            cmd.fall = 1'b1;
            if (stat.bitLast && stat.byteLast) begin
              cmd.endFrame = 1'b1;
              gapHalfNxt   = 1'b0;
              stateNxt     = S_GAP;
            end
          end
        end
      end
      S_GAP: begin
        if (stat.tick) begin
          if (gapHalf) begin
            cmd.advance = 1'b1;
            stateNxt    = S_NEXT;
          end else begin
            gapHalfNxt = 1'b1;
          end
        end
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      gapHalf <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      state   <= stateNxt;
      gapHalf <= gapHalfNxt;
      errQ    <= (state == S_IDLE) && reqValid && lenBad;
    end
  end

  assign busy = (state == S_NEXT) || (state == S_SHIFT) || (state == S_GAP);
  assign done = (state == S_DONE);
  assign err  = errQ;

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid)); // R9
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> !err); // R10
endmodule

// File: rtl/spib_datapath.sv
`timescale 1ns/1ps
module spib_datapath
  import spib_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int LEN_W     = 16,
  parameter int MAX_BYTES = 256,
  parameter int HALF_DIV  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  dpCmd_t            cmd,
  output dpStat_t           stat,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso,
  output logic [LEN_W-1:0]  bufRdAddr,
  input  logic [7:0]        bufRdData,
  output logic              bufWrEn,
  output logic [LEN_W-1:0]  bufWrAddr,
  output logic [7:0]        bufWrData
);
  localparam int CHUNK_W = $clog2(MAX_BYTES + 1);
  localparam int FRAME_W = $clog2(MAX_BYTES + HDR_BYTES + 1);
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int AFLD_W  = 21;
  localparam int CFLD_W  = 6;

  logic               isWrite;
  logic [ADDR_W-1:0]  wordAddr;
  logic [LEN_W-1:0]   bufBase;
  logic [LEN_W-1:0]   remLen;
  logic [CHUNK_W-1:0] chunkLen;
  logic [CHUNK_W-1:0] nextChunk;
  logic [FRAME_W-1:0] byteIdx;
  logic [FRAME_W-1:0] nextIdx;
  logic [2:0]         bitIdx;
  logic [7:0]         txSh;
  logic [7:0]         rxSh;
  logic [7:0]         nextByte;
  logic               sclkQ;
  logic               csQ;
  logic [DIV_W-1:0]   divCnt;
  logic               tick;
  logic [31:0]        hdrCur;
  logic [31:0]        hdrNew;

  function automatic logic [31:0] mkHdr(input logic w,
                                        input logic [CHUNK_W-1:0] len,
                                        input logic [ADDR_W-1:0] a);
    logic [CFLD_W-1:0] cnt;
    logic [AFLD_W-1:0] af;
    cnt = w ? '0 : CFLD_W'(len >> 2);
    af  = AFLD_W'(a);
    return {w, cnt, af, 4'b0000};
  endfunction

  assign nextChunk = (remLen > LEN_W'(MAX_BYTES)) ? CHUNK_W'(MAX_BYTES)
                                                  : CHUNK_W'(remLen);
  assign hdrNew = mkHdr(isWrite, nextChunk, wordAddr);
  assign hdrCur = mkHdr(isWrite, chunkLen, wordAddr);
  assign nextIdx = byteIdx + FRAME_W'(1);

  // byte loaded into the shifter at a byte boundary
  always_comb begin
    if (nextIdx < FRAME_W'(HDR_BYTES)) begin
      case (nextIdx[1:0])
        2'd1:    nextByte = hdrCur[23:16];
        2'd2:    nextByte = hdrCur[15:8];
        default: nextByte = hdrCur[7:0];
      endcase
    end else if (isWrite) begin
      nextByte = bufRdData;
    end else begin
      nextByte = 8'h00;
    end
  end

  assign bufRdAddr = bufBase + LEN_W'(byteIdx) - LEN_W'(HDR_BYTES - 1);

  assign tick = (divCnt == DIV_W'(HALF_DIV - 1));

  assign stat.remZero  = (remLen == '0);
  assign stat.tick     = tick;
  assign stat.sclkHigh = sclkQ;
  assign stat.bitLast  = (bitIdx == 3'd7);
  assign stat.byteLast = (byteIdx == FRAME_W'(chunkLen) + FRAME_W'(HDR_BYTES - 1));

  // SCK divider, restarted at each frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (cmd.startFrame || cmd.endFrame || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // request and chunk bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite  <= 1'b0;
      wordAddr <= '0;
      bufBase  <= '0;
      remLen   <= '0;
      chunkLen <= '0;
    end else begin
      if (cmd.latchReq) begin
        isWrite  <= reqWrite;
        wordAddr <= reqAddr;
        bufBase  <= '0;
        remLen   <= reqLen;
      end
      if (cmd.startFrame) begin
        chunkLen <= nextChunk;
      end
      if (cmd.advance) begin
        wordAddr <= wordAddr + ADDR_W'(chunkLen >> 2);
        bufBase  <= bufBase + LEN_W'(chunkLen);
        remLen   <= remLen - LEN_W'(chunkLen);
      end
    end
  end

  // shift engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ       <= 1'b1;
      sclkQ     <= 1'b0;
      txSh      <= '0;
      rxSh      <= '0;
      byteIdx   <= '0;
      bitIdx    <= '0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
    end else begin
      bufWrEn <= 1'b0;
      if (cmd.startFrame) begin
        csQ     <= 1'b0;
        sclkQ   <= 1'b0;
        txSh    <= hdrNew[31:24];
        byteIdx <= '0;
        bitIdx  <= '0;
      end
      if (cmd.rise) begin
        sclkQ <= 1'b1;
        rxSh  <= {rxSh[6:0], miso};
      end
      if (cmd.fall) begin
        sclkQ <= 1'b0;
        if (bitIdx == 3'd7) begin
          if (!isWrite && (byteIdx >= FRAME_W'(HDR_BYTES))) begin
            bufWrEn   <= 1'b1;
            bufWrAddr <= bufBase + LEN_W'(byteIdx) - LEN_W'(HDR_BYTES);
            bufWrData <= rxSh;
          end
          byteIdx <= nextIdx;
          bitIdx  <= '0;
          txSh    <= nextByte;
        end else begin
          bitIdx <= bitIdx + 3'd1;
          txSh   <= {txSh[6:0], 1'b0};
        end
      end
      if (cmd.endFrame) begin
        csQ <= 1'b1;
      end
    end
  end

  assign sclk = sclkQ;
  assign csN  = csQ;
  assign mosi = !csQ && txSh[7];

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R8
  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> (chunkLen != '0) && (chunkLen <= CHUNK_W'(MAX_BYTES))); // R1
  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> (remLen < $past(remLen))); // R3
  AST_WR_ONLY_READS: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> !isWrite); // R5
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
  import spib_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int LEN_W     = 16,
  parameter int MAX_BYTES = 256,
  parameter int HALF_DIV  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSingle,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso,
  output logic [LEN_W-1:0]  bufRdAddr,
  input  logic [7:0]        bufRdData,
  output logic              bufWrEn,
  output logic [LEN_W-1:0]  bufWrAddr,
  output logic [7:0]        bufWrData
);
  dpCmd_t  cmd;
  dpStat_t stat;

  spib_ctrl #(
    .LEN_W     (LEN_W),
    .MAX_BYTES (MAX_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSingle (reqSingle),
    .reqLen    (reqLen),
    .stat      (stat),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  spib_datapath #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MAX_BYTES (MAX_BYTES),
    .HALF_DIV  (HALF_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .cmd       (cmd),
    .stat      (stat),
    .sclk      (sclk),
    .csN       (csN),
    .mosi      (mosi),
    .miso      (miso),
    .bufRdAddr (bufRdAddr),
    .bufRdData (bufRdData),
    .bufWrEn   (bufWrEn),
    .bufWrAddr (bufWrAddr),
    .bufWrData (bufWrData)
  );
endmodule

// File: tb/spi_burst_master_bench.sv
`timescale 1ns/1ps
module spi_burst_master_bench;
  localparam int ADDR_W    = 21;
  localparam int LEN_W     = 16;
  localparam int MAX_BYTES = 256;
  localparam int HALF_DIV  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN;
  logic              reqValid, reqWrite, reqSingle;
  logic [ADDR_W-1:0] reqAddr;
  logic [LEN_W-1:0]  reqLen;
  logic              busy, done, err;
  logic              sclk, csN, mosi, miso;
  logic [LEN_W-1:0]  bufRdAddr, bufWrAddr;
  logic [7:0]        bufRdData, bufWrData;
  logic              bufWrEn;

  spi_burst_master #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES), .HALF_DIV(HALF_DIV)
  ) u_spi_burst_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSingle(reqSingle), .reqAddr(reqAddr), .reqLen(reqLen),
    .busy(busy), .done(done), .err(err), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso), .bufRdAddr(bufRdAddr), .bufRdData(bufRdData),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // local buffer model
  logic [7:0] srcMem [0:1023];
  logic [7:0] dstMem [0:1023];
  logic       dstClr = 1'b0;
  assign bufRdData = srcMem[bufRdAddr[9:0]];

  always @(posedge clk) begin
    if (dstClr) begin
      for (int i = 0; i < 1024; i++) dstMem[i] <= 8'h00;
    end else if (bufWrEn) begin
      dstMem[bufWrAddr[9:0]] <= bufWrData;
    end
  end

  // SPI device model
  int xferId = 0;
  function automatic logic [7:0] slvByte(input int x, input int f, input int k);
    return 8'((k * 5 + f * 29 + x * 71 + 3) & 255);
  endfunction

  logic        slvClr = 1'b0;
  logic        prevCs = 1'b1;
  logic        prevSclk = 1'b0;
  logic        misoQ = 1'b0;
  logic [7:0]  curByte;
  logic [7:0]  tmpByte;
  logic [31:0] hdrArr [0:15];
  int          lenArr [0:15];
  logic [7:0]  capMem [0:1023];
  int bitCnt = 0, byteK = 0, frameIdx = 0, payOff = 0;
  int gapCnt = 0, gapMin = 1000000, sclkBad = 0;
  assign miso = misoQ;

  always @(negedge clk) begin
    if (slvClr) begin
      frameIdx = 0; payOff = 0; gapCnt = 0; gapMin = 1000000; sclkBad = 0;
    end else begin
      if (csN && sclk) sclkBad++;
      if (prevCs && !csN) begin
        if (frameIdx > 0 && gapCnt < gapMin) gapMin = gapCnt;
        bitCnt = 0; byteK = 0; curByte = 8'h00;
        if (frameIdx < 16) hdrArr[frameIdx] = 32'h0;
        tmpByte = slvByte(xferId, frameIdx, 0);
        misoQ = tmpByte[7];
      end else if (!prevCs && csN) begin
        if (frameIdx < 16) lenArr[frameIdx] = byteK;
        payOff = payOff + byteK - 4;
        frameIdx++;
        gapCnt = 0;
      end else if (!csN) begin
        if (!prevSclk && sclk) begin
          curByte = {curByte[6:0], mosi};
          bitCnt++;
          if (bitCnt == 8) begin
            if (byteK < 4) begin
              if (frameIdx < 16) hdrArr[frameIdx] = {hdrArr[frameIdx][23:0], curByte};
            end else begin
              capMem[(payOff + byteK - 4) & 1023] = curByte;
            end
            byteK++;
            bitCnt = 0;
          end
        end else if (prevSclk && !sclk) begin
          tmpByte = slvByte(xferId, frameIdx, byteK);
          misoQ = tmpByte[7 - bitCnt];
        end
      end
      if (csN) gapCnt++;
    end
    prevCs = csN;
    prevSclk = sclk;
  end

  task automatic clearModels();
    xferId++;
    slvClr = 1'b1; dstClr = 1'b1;
    @(negedge clk);
    slvClr = 1'b0; dstClr = 1'b0;
  endtask

  task automatic runXfer(input logic wr, input logic single, input int addr,
                         input int len, input bit poke);
    int cyc, busyDrop, errSeen, nf, chunk, badPay, badZero;
    logic [31:0] expH;
    clearModels();
    reqValid = 1'b1; reqWrite = wr; reqSingle = single;
    reqAddr = ADDR_W'(addr); reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", longint'(busy), 1);
    cyc = 0; busyDrop = 0; errSeen = 0;
    while (!done && cyc < 60000) begin
      if (poke && cyc == 40) begin
        reqValid = 1'b1; reqWrite = ~wr; reqLen = LEN_W'(8); reqSingle = 1'b0;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (!done && !busy) busyDrop++;
      if (err) errSeen++;
    end
    reqValid = 1'b0;
    chk(done == 1'b1, "R9", "done reached", longint'(done), 1);
    chk(busy == 1'b0, "R9", "busy low in done cycle", longint'(busy), 0);
    chk(busyDrop == 0, "R9", "busy held until done", busyDrop, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", longint'(done), 0);
    repeat (40) @(negedge clk);
    nf = (len + MAX_BYTES - 1) / MAX_BYTES;
    chk(frameIdx == nf, "R1", "frame count", frameIdx, nf);
    if (poke) chk(errSeen == 0, "R10", "no error for request while busy", errSeen, 0);
    chk(sclkBad == 0, "R8", "sclk high while deselected", sclkBad, 0);
    if (nf > 1) chk(gapMin >= 2 * HALF_DIV, "R8", "idle gap cycles", gapMin, 2 * HALF_DIV);
    for (int f = 0; f < nf && f < 16; f++) begin
      chunk = (len - f * MAX_BYTES > MAX_BYTES) ? MAX_BYTES : len - f * MAX_BYTES;
      chk(lenArr[f] == chunk + 4, "R1", "frame byte length", lenArr[f], chunk + 4);
      expH = {wr, (wr ? 6'd0 : 6'((chunk / 4) % 64)),
              21'((addr + f * (MAX_BYTES / 4)) & 32'h1FFFFF), 4'b0000};
      chk(hdrArr[f] == expH, "R2", "command word", hdrArr[f], expH);
      chk(hdrArr[f][24:4] == 21'((addr + f * (MAX_BYTES / 4)) & 32'h1FFFFF), "R3",
          "frame word address", hdrArr[f][24:4], (addr + f * (MAX_BYTES / 4)) & 32'h1FFFFF);
      badPay = 0; badZero = 0;
      for (int j = 0; j < chunk; j++) begin
        if (wr) begin
          if (capMem[f * MAX_BYTES + j] !== srcMem[f * MAX_BYTES + j]) badPay++;
        end else begin
          if (dstMem[f * MAX_BYTES + j] !== slvByte(xferId, f, j + 4)) badPay++;
          if (capMem[f * MAX_BYTES + j] !== 8'h00) badZero++;
        end
      end
      if (wr) chk(badPay == 0, "R4", "write payload mismatches", badPay, 0);
      else begin
        chk(badPay == 0, "R5", "read capture mismatches", badPay, 0);
        chk(badZero == 0, "R5", "nonzero MOSI in read payload", badZero, 0);
      end
    end
    if (!wr) begin
      badPay = 0;
      for (int j = len; j < 1024; j++) if (dstMem[j] !== 8'h00) badPay++;
      chk(badPay == 0, "R5", "writes beyond payload", badPay, 0);
    end
  endtask

  task automatic rejectXfer(input logic single, input int len, input string req);
    clearModels();
    reqValid = 1'b1; reqWrite = 1'b1; reqSingle = single;
    reqAddr = ADDR_W'(32'h00200); reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, req, "refusal err/busy", {err, busy}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, req, "err single cycle", longint'(err), 0);
    repeat (200) @(negedge clk);
    chk(frameIdx == 0 && busy == 1'b0, req, "no frame after refusal", frameIdx, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) srcMem[i] = 8'((i * 7 + 1) & 255);
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqSingle = 1'b0;
    reqAddr = '0; reqLen = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0, "R8", "reset bus state", {csN, sclk}, 2'b10);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R9", "reset flags",
        {busy, done, err}, 0);
    runXfer(1'b1, 1'b0, 32'h20000, 0,   1'b0);
    runXfer(1'b1, 1'b0, 32'h12340, 4,   1'b0);
    runXfer(1'b0, 1'b0, 32'h00100, 12,  1'b0);
    runXfer(1'b1, 1'b0, 32'h0ABC0, 256, 1'b0);
    runXfer(1'b0, 1'b0, 32'h1FF00, 256, 1'b0);
    runXfer(1'b1, 1'b0, 32'h00040, 260, 1'b0);
    runXfer(1'b0, 1'b0, 32'h03000, 520, 1'b1);
    runXfer(1'b1, 1'b1, 32'h00400, 256, 1'b0);
    rejectXfer(1'b0, 6,   "R6");
    rejectXfer(1'b0, 2,   "R6");
    rejectXfer(1'b1, 260, "R7");
    rejectXfer(1'b1, 512, "R7");
    runXfer(1'b0, 1'b0, 32'h1FFC0, 600, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule